// File: doc/BRIEF.md
# Three-Phase Direct Digital Synthesis Phase Engine

This block is the phase engine of a three-output direct digital synthesizer. A 32-bit phase register advances by a programmable frequency word on every clock where the enable is high, and wraps modulo 2^32. A phase word is added to the register, and the top 12 bits of that sum become the lookup address of the lead output, phase A. The output frequency is fclk·F/2^32, so one step of the frequency word moves the output by fclk/2^32.

Each of the other two outputs is the previous one plus a latched offset. Phase B is A plus the A-to-B offset, and phase C is B plus the B-to-C offset, all modulo 4096. A 12-bit offset resolves about 0.088 degrees, which is finer than one degree. Each offset register changes only when its load strobe is high. All three addresses are registered in the same stage, so they always come from the same phase register value. A waveform table or shaper downstream uses the addresses. One address period of 4096 points is one full waveform cycle.

Top module: `tri_phase_dds`

## Requirements
- R1: While reset is asserted, and after it is released, the phase register, both offset registers and all three addresses are zero. Asserting rst_n low clears the addresses at once, without waiting for a clock edge.
- R2: On a clock edge with en=1, the phase register becomes its old value plus freq_word, modulo 2^32.
- R3: On a clock edge with en=0, the phase register keeps its value.
- R4: addr_a is bits 31..20 of (phase register + phase_word) mod 2^32, taken before that edge.
- R5: addr_b equals (addr_a + A-to-B offset) mod 4096.
- R6: addr_c equals (addr_b + B-to-C offset) mod 4096, which is (addr_a + both offsets) mod 4096.
- R7: An offset register changes only on a clock edge where its own strobe is high. Offset data presented while the strobe is low has no effect on any address.
- R8: An offset loaded at edge k first shows in the addresses registered at edge k+1. The addresses registered at edge k still use the previous offset.
- R9: The addresses are registered. A change of phase_word or freq_word between edges does not change any output until the next rising edge.
- R10: With freq_word = 2^20 and en=1, addr_a rises by exactly one per clock and wraps from 4095 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Asserts at once and is released synchronously inside the block |
| en | input | 1 | Enable for the phase register |
| freq_word | input | 32 | Step added to the phase register on each enabled edge |
| phase_word | input | 32 | Static phase added before the address is taken |
| ab_load | input | 1 | Strobe that loads ab_offset |
| ab_offset | input | 12 | Offset from phase A to phase B, in address units |
| bc_load | input | 1 | Strobe that loads bc_offset |
| bc_offset | input | 12 | Offset from phase B to phase C, in address units |
| addr_a | output | 12 | Registered phase A lookup address |
| addr_b | output | 12 | Registered phase B lookup address |
| addr_c | output | 12 | Registered phase C lookup address |

## Verification
The bench drives frequency words that wrap the phase register, including all-ones (a step of minus one), half scale and one LSB. A design that dropped the carry out of bit 31 or slipped the address slice would then show a wrong addr_a. It chooses offsets whose sums pass 4096, and an offset of all-ones that puts C one step behind B. A chain that was wider than 12 bits, or that added both offsets to A in the wrong order, would give a wrong phase C. It drives offset data with the strobe low, and it loads an offset in the same cycle as it checks the addresses. A latch that was transparent, or one that took effect a cycle early, would move addr_b or addr_c too soon. A long run at a step of exactly one address LSB checks the wrap from 4095 to 0. A reset asserted mid-run checks that the addresses and offsets clear at once.

// File: rtl/tpd_pkg.sv
package tpd_pkg;
  // number of output phases in the offset chain
  localparam int NUM_PHASES  = 3;
  localparam int NUM_OFFSETS = NUM_PHASES - 1;
endpackage

// File: rtl/tpd_phase_acc.sv
module tpd_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] acc_q
);
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    acc_d = acc_q;
    if (en) acc_d = acc_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/tpd_offset_reg.sv
module tpd_offset_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load) q_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/tpd_addr_chain.sv
module tpd_addr_chain #(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 12,
  parameter int NPH    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ACC_W-1:0]            acc,
  input  logic [ACC_W-1:0]            pword,
  input  logic [NPH-2:0][ADDR_W-1:0]  ofs,
  output logic [NPH-1:0][ADDR_W-1:0]  addr_q
);
  localparam int TOP_LSB = ACC_W - ADDR_W;

  logic [NPH-1:0][ADDR_W-1:0] addr_d;

  // lead phase: top bits of accumulator plus static phase
  assign addr_d[0] = ADDR_W'((acc + pword) >> TOP_LSB);

  // each following phase adds its offset to the one before it
  for (genvar g = 1; g < NPH; g++) begin : g_link
    assign addr_d[g] = addr_d[g-1] + ofs[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end
endmodule

// File: rtl/tri_phase_dds.sv
module tri_phase_dds #(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ACC_W-1:0]  freq_word,
  input  logic [ACC_W-1:0]  phase_word,
  input  logic              ab_load,
  input  logic [ADDR_W-1:0] ab_offset,
  input  logic              bc_load,
  input  logic [ADDR_W-1:0] bc_offset,
  output logic [ADDR_W-1:0] addr_a,
  output logic [ADDR_W-1:0] addr_b,
  output logic [ADDR_W-1:0] addr_c
);
  import tpd_pkg::*;

  // reset asserts at once, releases after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic [ACC_W-1:0] acc_q;

  tpd_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_core_n),
    .en    (en),
    .step  (freq_word),
    .acc_q (acc_q)
  );

  logic [NUM_OFFSETS-1:0]             ld_vec;
  logic [NUM_OFFSETS-1:0][ADDR_W-1:0] ofs_in;
  logic [NUM_OFFSETS-1:0][ADDR_W-1:0] ofs_q;

  assign ld_vec = {bc_load, ab_load};
  assign ofs_in = {bc_offset, ab_offset};

  for (genvar g = 0; g < NUM_OFFSETS; g++) begin : g_ofs
    tpd_offset_reg #(.W(ADDR_W)) u_ofs (
      .clk   (clk),
      .rst_n (rst_core_n),
      .load  (ld_vec[g]),
      .din   (ofs_in[g]),
      .q     (ofs_q[g])
    );
  end

  logic [NUM_PHASES-1:0][ADDR_W-1:0] addr_q;

  tpd_addr_chain #(.ACC_W(ACC_W), .ADDR_W(ADDR_W), .NPH(NUM_PHASES)) u_chain (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .acc    (acc_q),
    .pword  (phase_word),
    .ofs    (ofs_q),
    .addr_q (addr_q)
  );

  assign addr_a = addr_q[0];
  assign addr_b = addr_q[1];
  assign addr_c = addr_q[2];
endmodule

// File: rtl/tpd_checker.sv
module tpd_checker #(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              en,
  input logic [ACC_W-1:0]  freq_word,
  input logic [ACC_W-1:0]  phase_word,
  input logic              ab_load,
  input logic [ADDR_W-1:0] ab_offset,
  input logic              bc_load,
  input logic [ADDR_W-1:0] bc_offset,
  input logic [ACC_W-1:0]  acc_q,
  input logic [ADDR_W-1:0] ofs_ab_q,
  input logic [ADDR_W-1:0] ofs_bc_q,
  input logic [ADDR_W-1:0] addr_a,
  input logic [ADDR_W-1:0] addr_b,
  input logic [ADDR_W-1:0] addr_c
);
  localparam int TOP_LSB = ACC_W - ADDR_W;

  // R2
  acc_step_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    en |=> acc_q == $past(acc_q + freq_word));

  // R3
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !en |=> $stable(acc_q));

  // R4
  lead_addr_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    rst_core_n |=> addr_a == $past(ADDR_W'((acc_q + phase_word) >> TOP_LSB)));

  // R5
  b_offset_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    rst_core_n |=> ADDR_W'(addr_b - addr_a) == $past(ofs_ab_q));

  // R6
  c_offset_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    rst_core_n |=> ADDR_W'(addr_c - addr_b) == $past(ofs_bc_q));

  // R7
  ab_keep_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !ab_load |=> $stable(ofs_ab_q));

  // R7
  bc_keep_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !bc_load |=> $stable(ofs_bc_q));

  // R8
  ab_take_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    ab_load |=> ofs_ab_q == $past(ab_offset));

  // R8
  bc_take_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    bc_load |=> ofs_bc_q == $past(bc_offset));
endmodule

bind tri_phase_dds tpd_checker #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .en         (en),
  .freq_word  (freq_word),
  .phase_word (phase_word),
  .ab_load    (ab_load),
  .ab_offset  (ab_offset),
  .bc_load    (bc_load),
  .bc_offset  (bc_offset),
  .acc_q      (acc_q),
  .ofs_ab_q   (ofs_q[0]),
  .ofs_bc_q   (ofs_q[1]),
  .addr_a     (addr_a),
  .addr_b     (addr_b),
  .addr_c     (addr_c)
);

// File: tb/tb_tri_phase_dds.sv
module tb_tri_phase_dds;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [31:0] freq_word, phase_word;
  logic        ab_load, bc_load;
  logic [11:0] ab_offset, bc_offset;
  logic [11:0] addr_a, addr_b, addr_c;

  always #2 clk = ~clk;

  tri_phase_dds dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .freq_word(freq_word), .phase_word(phase_word),
    .ab_load(ab_load), .ab_offset(ab_offset),
    .bc_load(bc_load), .bc_offset(bc_offset),
    .addr_a(addr_a), .addr_b(addr_b), .addr_c(addr_c)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // model state
  logic [31:0] m_acc;
  logic [11:0] m_ab, m_bc;

  // {en, freq, phase, ab_load, ab_off, bc_load, bc_off}
  localparam int NV = 10;
  localparam logic [90:0] VEC [NV] = '{
    {1'b1, 32'h0010_0000, 32'h0000_0000, 1'b1, 12'd1365, 1'b1, 12'd1365},
    {1'b1, 32'h0010_0000, 32'h0000_0000, 1'b0, 12'hFFF,  1'b0, 12'h123},
    {1'b1, 32'h0123_4567, 32'h0000_0000, 1'b0, 12'h0AA,  1'b0, 12'h055},
    {1'b0, 32'h0123_4567, 32'h0000_0000, 1'b0, 12'h000,  1'b0, 12'h000},
    {1'b0, 32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 12'h000,  1'b0, 12'h000},
    {1'b1, 32'hFFFF_FFFF, 32'hFFF0_0000, 1'b0, 12'h000,  1'b0, 12'h000},
    {1'b1, 32'h8000_0000, 32'h0000_0000, 1'b1, 12'd0,    1'b0, 12'h000},
    {1'b1, 32'h8000_0000, 32'h0000_0000, 1'b0, 12'h000,  1'b1, 12'hFFF},
    {1'b1, 32'h0000_0001, 32'h000F_FFFF, 1'b1, 12'd2048, 1'b1, 12'd2048},
    {1'b1, 32'h7FFF_FFFF, 32'h1234_5678, 1'b0, 12'h000,  1'b0, 12'h000}
  };

  task automatic chk3(input string tag, input logic [11:0] ea, eb, ec);
    n_chk++;
    if (addr_a !== ea || addr_b !== eb || addr_c !== ec) begin
      n_fail++;
      $display("FAIL %s: got a=%0d b=%0d c=%0d expected a=%0d b=%0d c=%0d",
               tag, addr_a, addr_b, addr_c, ea, eb, ec);
    end
  endtask

  // drive at a falling edge, model one rising edge, compare at next falling edge
  task automatic apply(input logic e, input logic [31:0] f, p,
                       input logic l1, input logic [11:0] o1,
                       input logic l2, input logic [11:0] o2,
                       input string tag);
    logic [31:0] s;
    logic [11:0] ea, eb, ec;
    en = e; freq_word = f; phase_word = p;
    ab_load = l1; ab_offset = o1; bc_load = l2; bc_offset = o2;
    s  = m_acc + p;
    ea = s[31:20];
    eb = ea + m_ab;
    ec = eb + m_bc;
    if (e)  m_acc = m_acc + f;
    if (l1) m_ab = o1;
    if (l2) m_bc = o2;
    @(negedge clk);
    chk3(tag, ea, eb, ec);
  endtask

  task automatic do_reset();
    en = 0; freq_word = 0; phase_word = 0;
    ab_load = 0; bc_load = 0; ab_offset = 0; bc_offset = 0;
    rst_n = 0;
    #1;
    chk3("R1 async clear", 12'd0, 12'd0, 12'd0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    m_acc = 0; m_ab = 0; m_bc = 0;
    chk3("R1 after release", 12'd0, 12'd0, 12'd0);
  endtask

  initial begin
    rst_n = 0;
    @(negedge clk);
    do_reset();

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][90], VEC[i][89:58], VEC[i][57:26], VEC[i][25], VEC[i][24:13],
            VEC[i][12], VEC[i][11:0], "R2 R3 R4 R5 R6 R7 table");
    end

    // R7: offset data without strobe is ignored over several cycles
    for (int i = 0; i < 4; i++)
      apply(1'b1, 32'h0031_0000, 32'h0, 1'b0, 12'(i * 321 + 7), 1'b0, 12'(i * 99 + 1),
            "R7 ignore");

    // R8: load in this cycle, old offset still used now, new one next cycle
    apply(1'b1, 32'h0010_0000, 32'h0, 1'b1, 12'd100, 1'b1, 12'd200, "R8 load edge");
    apply(1'b1, 32'h0010_0000, 32'h0, 1'b0, 12'd0, 1'b0, 12'd0, "R8 next edge");
    n_chk++;
    if (12'(addr_b - addr_a) !== 12'd100 || 12'(addr_c - addr_b) !== 12'd200) begin
      n_fail++;
      $display("FAIL R8: got b-a=%0d c-b=%0d expected 100 200",
               12'(addr_b - addr_a), 12'(addr_c - addr_b));
    end

    // R9: an input change between edges leaves outputs alone until the edge
    begin
      logic [11:0] ha, hb, hc;
      ha = addr_a; hb = addr_b; hc = addr_c;
      phase_word = 32'h4000_0000; freq_word = 32'h1357_9BDF; en = 1'b0;
      #1;
      chk3("R9 no change before edge", ha, hb, hc);
      apply(1'b0, 32'h1357_9BDF, 32'h4000_0000, 1'b0, 12'd0, 1'b0, 12'd0, "R9 after edge");
    end

    // R1 mid-run reset clears offsets too
    do_reset();
    apply(1'b0, 32'h0, 32'h0, 1'b0, 12'd0, 1'b0, 12'd0, "R1 offsets cleared");

    // R10: one address step per clock, wrap 4095 -> 0
    begin
      logic [11:0] prev;
      bit wrapped = 1'b0;
      prev = addr_a;
      for (int i = 0; i < 4100; i++) begin
        apply(1'b1, 32'h0010_0000, 32'h0, 1'b0, 12'd0, 1'b0, 12'd0, "R10 sweep");
        if (i > 0) begin
          n_chk++;
          if (addr_a !== 12'(prev + 12'd1)) begin
            n_fail++;
            $display("FAIL R10: got a=%0d expected %0d", addr_a, 12'(prev + 12'd1));
          end
          if (prev == 12'd4095 && addr_a == 12'd0) wrapped = 1'b1;
        end
        prev = addr_a;
      end
      n_chk++;
      if (!wrapped) begin
        n_fail++;
        $display("FAIL R10: got no wrap expected wrap 4095->0");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule